// File: doc/BRIEF.md
# Page-Mode Asynchronous DRAM Controller

This block sits between a single host port and an asynchronous DRAM with row and column strobes. A host request carries a flat word address, a write flag and write data. The controller splits the address into a row part and a column part and drives them one after the other on one narrow address bus. It then sequences the row strobe, the column strobe, the write strobe and the output enable. The host holds its request until a one-cycle acknowledge comes back. On a read, the acknowledge arrives together with the captured data.

After an access the row strobe stays low, so the row remains open. Any later access to the same row costs only a column cycle. An access to another row first closes the open row with a precharge. Refresh belongs to the controller. An internal row counter supplies the row for each strobe-only refresh cycle. A mode input selects one of two schedules: one row at even intervals, or every row back to back once per refresh period. A pending refresh is served before any host request.

Top module: `dpc_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are high, `dram_dq_oe` is low and `host_ack` is low.
- R2: The upper ROW_W bits of `host_addr` form the row and the lower COL_W bits form the column. The row is on `dram_addr`, zero-extended, when RAS falls. The column is on `dram_addr` when CAS falls.
- R3: A request whose row equals the open row produces a CAS cycle with no new fall of RAS.
- R4: A request to a different row first raises RAS. Before any fall of RAS, RAS has been high for at least T_RP cycles.
- R5: CAS is never low while RAS is high. RAS has been low for at least T_RCD cycles when CAS falls. Every CAS low pulse lasts exactly T_CAS cycles.
- R6: In a write, `dram_we_n` is low in the cycle before CAS falls and stays low while CAS is low. `dram_dq_oe` is high and `dram_dq_out` carries the write data.
- R7: In a read, `dram_we_n` stays high and `dram_oe_n` is low while CAS is low. `host_rdata` holds the word the DRAM presents in the last CAS-low cycle. `dram_oe_n` is never low during a write.
- R8: `host_ack` is a single-cycle pulse, one per request, given with RAS low and CAS high. On a read, `host_rdata` is valid in that cycle.
- R9: A refresh is a RAS low pulse with no CAS pulse. Its row comes from a counter that advances by one per refresh and wraps from 2^ROW_W-1 to 0.
- R10: With `ref_burst` low and the host idle, single-row refreshes start exactly REF_INTERVAL cycles apart.
- R11: With `ref_burst` high, all 2^ROW_W rows are refreshed back to back once every 2^ROW_W*REF_INTERVAL cycles. Consecutive refreshes in a burst start T_ASR+T_RAS+T_RP+1 cycles apart.
- R12: A pending refresh wins over a host request. An open row is precharged first, and the next access to that row is handled as a page miss with a new RAS fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_burst | input | 1 | Refresh schedule: 0 spread evenly, 1 all rows in a burst |
| host_req | input | 1 | Request; held with its fields until acknowledged |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ROW_W+COL_W | Word address, row in the upper bits |
| host_wdata | input | DATA_W | Write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W | Read data, valid with the acknowledge |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DATA_W | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Enable for the data driver |
| dram_dq_in | input | DATA_W | Data returned by the DRAM |

## Verification
The checker watches the strobes on every cycle. It checks that CAS stays inside RAS, the minimum row-to-column delay, the exact CAS width, the minimum RAS-high precharge, the write strobe leading CAS, that the output enable never appears in a write, and that the acknowledge is a single pulse. Other behaviour only shows over a whole scenario, so the bench's DRAM model and scoreboard cover it. That covers data returned to the right address, page hits without a new activation, the row after a refresh being treated as a miss, the refresh row sequence and its wrap, the exact spacing of distributed refreshes, and the length of a refresh burst.

// File: rtl/dpc_pkg.sv
// Shared types for the page-mode DRAM controller.
// Assumes nothing beyond a common compile unit order (package first).
package dpc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ACT_SETUP,
        ST_ACT_RCD,
        ST_COL_SETUP,
        ST_COL_STROBE,
        ST_COL_END,
        ST_PRECH,
        ST_REF_SETUP,
        ST_REF_RAS,
        ST_REF_PRE
    } dpc_state_e;

endpackage

// File: rtl/dpc_wait_timer.sv
// Down-counter that times how long the sequencer stays in a state.
// A load writes the cycle count minus one; done is high when the count is zero.
// Assumes a load is never requested while the loaded value is needed as done.
module dpc_wait_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] value,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    // Load on state entry, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= value;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/dpc_refresh_sched.sv
// Refresh scheduler: counts refresh intervals, keeps the number of rows owed,
// and holds the row counter for the next strobe-only refresh.
// Distributed mode owes one row per interval; burst mode owes all rows once
// every 2^ROW_W intervals. Assumes ref_done pulses once per finished refresh.
module dpc_refresh_sched #(
    parameter int ROW_W        = 4,
    parameter int REF_INTERVAL = 150
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             burst_mode,
    input  logic             ref_done,
    output logic             ref_req,
    output logic [ROW_W-1:0] ref_row
);
    localparam int NUM_ROWS = 1 << ROW_W;
    localparam int IW       = $clog2(REF_INTERVAL);
    localparam int OW       = ROW_W + 1;

    logic [IW-1:0]    intv_q;
    logic [ROW_W-1:0] per_q;
    logic [OW-1:0]    owed_q;
    logic [ROW_W-1:0] row_q;
    logic             tick;

    assign tick = (intv_q == IW'(REF_INTERVAL - 1));

    // Interval counter producing one tick every REF_INTERVAL cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    intv_q <= '0;
        else if (tick) intv_q <= '0;
        else           intv_q <= intv_q + 1'b1;
    end

    // Counts ticks within one full refresh period for burst mode.
    always_ff @(posedge clk) begin
        if (!rst_n)    per_q <= '0;
        else if (tick) per_q <= per_q + 1'b1;
    end

    // Number of rows still owed, per the selected schedule.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed_q <= '0;
        end else if (burst_mode) begin
            if (tick && (per_q == '1))  owed_q <= OW'(NUM_ROWS);
            else if (ref_done)          owed_q <= owed_q - 1'b1;
        end else begin
            if (tick && !ref_done && (owed_q != OW'(NUM_ROWS))) owed_q <= owed_q + 1'b1;
            else if (!tick && ref_done)                         owed_q <= owed_q - 1'b1;
        end
    end

    // Refresh row counter, wraps naturally after the last row.
    always_ff @(posedge clk) begin
        if (!rst_n)        row_q <= '0;
        else if (ref_done) row_q <= row_q + 1'b1;
    end

    assign ref_req = (owed_q != '0);
    assign ref_row = row_q;
endmodule

// File: rtl/dpc_ctrl.sv
// Page-mode controller for an asynchronous DRAM.
// Keeps the last row open, serves same-row hits with a column cycle only,
// precharges on a miss, and interleaves strobe-only refresh from the scheduler.
// Assumes the host holds request fields stable until host_ack and that all
// timing parameters are at least 1 cycle.
module dpc_ctrl
    import dpc_pkg::*;
#(
    parameter int ROW_W        = 4,
    parameter int COL_W        = 4,
    parameter int DATA_W       = 8,
    parameter int T_ASR        = 1,
    parameter int T_RCD        = 2,
    parameter int T_CAS        = 2,
    parameter int T_RP         = 2,
    parameter int T_RAS        = 3,
    parameter int REF_INTERVAL = 150
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ref_burst,
    input  logic                     host_req,
    input  logic                     host_we,
    input  logic [ROW_W+COL_W-1:0]   host_addr,
    input  logic [DATA_W-1:0]        host_wdata,
    output logic                     host_ack,
    output logic [DATA_W-1:0]        host_rdata,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
    output logic                     dram_ras_n,
    output logic                     dram_cas_n,
    output logic                     dram_we_n,
    output logic                     dram_oe_n,
    output logic [DATA_W-1:0]        dram_dq_out,
    output logic                     dram_dq_oe,
    input  logic [DATA_W-1:0]        dram_dq_in
);
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int AW     = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int MAXD_A = (T_ASR > T_RCD) ? T_ASR : T_RCD;
    localparam int MAXD_B = (T_CAS > T_RP) ? T_CAS : T_RP;
    localparam int MAXD_C = (MAXD_A > MAXD_B) ? MAXD_A : MAXD_B;
    localparam int MAXD   = (MAXD_C > T_RAS) ? MAXD_C : T_RAS;
    localparam int TW     = $clog2(MAXD) + 1;

    dpc_state_e       state_q, state_d;
    logic             tmr_load, tmr_done;
    logic             ref_req, ref_done;
    logic [ROW_W-1:0] ref_row;
    logic             row_open;
    logic [ROW_W-1:0] open_row, cur_row;
    logic [COL_W-1:0] cur_col;
    logic             cur_we;
    logic [DATA_W-1:0] cur_wdata, rdata_q;
    logic             page_hit;

    // Cycle count, minus one, for each timed state.
    function automatic logic [TW-1:0] dwell(dpc_state_e s);
        case (s)
            ST_ACT_SETUP, ST_REF_SETUP: return TW'(T_ASR - 1);
            ST_ACT_RCD:                 return TW'(T_RCD - 1);
            ST_COL_STROBE:              return TW'(T_CAS - 1);
            ST_PRECH, ST_REF_PRE:       return TW'(T_RP - 1);
            ST_REF_RAS:                 return TW'(T_RAS - 1);
            default:                    return '0;
        endcase
    endfunction

    dpc_refresh_sched #(
        .ROW_W        (ROW_W),
        .REF_INTERVAL (REF_INTERVAL)
    ) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .burst_mode (ref_burst),
        .ref_done   (ref_done),
        .ref_req    (ref_req),
        .ref_row    (ref_row)
    );

    dpc_wait_timer #(.CW(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .value (dwell(state_d)),
        .done  (tmr_done)
    );

    assign page_hit = row_open && (host_addr[ADDR_W-1:COL_W] == open_row);

    // Next-state choice: refresh first, then hit, miss or fresh activation.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (ref_req)        state_d = row_open ? ST_PRECH : ST_REF_SETUP;
                else if (host_req) begin
                    if (page_hit)      state_d = ST_COL_SETUP;
                    else if (row_open) state_d = ST_PRECH;
                    else               state_d = ST_ACT_SETUP;
                end
            end
            ST_ACT_SETUP:  if (tmr_done) state_d = ST_ACT_RCD;
            ST_ACT_RCD:    if (tmr_done) state_d = ST_COL_SETUP;
            ST_COL_SETUP:  if (tmr_done) state_d = ST_COL_STROBE;
            ST_COL_STROBE: if (tmr_done) state_d = ST_COL_END;
            ST_COL_END:    state_d = ST_IDLE;
            ST_PRECH:      if (tmr_done) state_d = ST_IDLE;
            ST_REF_SETUP:  if (tmr_done) state_d = ST_REF_RAS;
            ST_REF_RAS:    if (tmr_done) state_d = ST_REF_PRE;
            ST_REF_PRE:    if (tmr_done) state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    assign tmr_load = (state_d != state_q);
    assign ref_done = (state_q == ST_REF_PRE) && tmr_done;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Latch the request fields when an access leaves idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_row   <= '0;
            cur_col   <= '0;
            cur_we    <= 1'b0;
            cur_wdata <= '0;
        end else if ((state_q == ST_IDLE) &&
                     (state_d == ST_ACT_SETUP || state_d == ST_COL_SETUP)) begin
            cur_row   <= host_addr[ADDR_W-1:COL_W];
            cur_col   <= host_addr[COL_W-1:0];
            cur_we    <= host_we;
            cur_wdata <= host_wdata;
        end
    end

    // Track which row is open: set on activation, cleared on precharge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_open <= 1'b0;
            open_row <= '0;
        end else if (state_d == ST_ACT_RCD && state_q == ST_ACT_SETUP) begin
            row_open <= 1'b1;
            open_row <= cur_row;
        end else if (state_d == ST_PRECH && state_q == ST_IDLE) begin
            row_open <= 1'b0;
        end
    end

    // Capture read data in the last cycle CAS is low.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if ((state_q == ST_COL_STROBE) && tmr_done && !cur_we)
            rdata_q <= dram_dq_in;
    end

    // Strobe and bus decode from the current state.
    always_comb begin
        dram_ras_n = 1'b1;
        dram_cas_n = 1'b1;
        dram_we_n  = 1'b1;
        dram_oe_n  = 1'b1;
        dram_dq_oe = 1'b0;
        dram_addr  = AW'(open_row);
        case (state_q)
            ST_IDLE:      dram_ras_n = !row_open;
            ST_ACT_SETUP: dram_addr  = AW'(cur_row);
            ST_ACT_RCD: begin
                dram_ras_n = 1'b0;
                dram_addr  = AW'(cur_row);
            end
            ST_COL_SETUP: begin
                dram_ras_n = 1'b0;
                dram_addr  = AW'(cur_col);
                dram_we_n  = !cur_we;
                dram_dq_oe = cur_we;
            end
            ST_COL_STROBE: begin
                dram_ras_n = 1'b0;
                dram_cas_n = 1'b0;
                dram_addr  = AW'(cur_col);
                dram_we_n  = !cur_we;
                dram_oe_n  = cur_we;
                dram_dq_oe = cur_we;
            end
            ST_COL_END: begin
                dram_ras_n = 1'b0;
                dram_addr  = AW'(cur_col);
            end
            ST_REF_SETUP, ST_REF_PRE: dram_addr = AW'(ref_row);
            ST_REF_RAS: begin
                dram_ras_n = 1'b0;
                dram_addr  = AW'(ref_row);
            end
            default: ;
        endcase
    end

    assign dram_dq_out = cur_wdata;
    assign host_ack    = (state_q == ST_COL_END);
    assign host_rdata  = rdata_q;
endmodule

// File: rtl/dpc_ctrl_chk.sv
// Protocol checker for dpc_ctrl, attached by bind.
// Watches only the DRAM strobes and the host acknowledge; the timing windows
// are measured with saturating counters rather than long $past chains.
module dpc_ctrl_chk #(
    parameter int T_RCD = 2,
    parameter int T_CAS = 2,
    parameter int T_RP  = 2,
    parameter int CNT_W = 8
) (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic oe_n,
    input logic dq_oe,
    input logic ack
);
    logic [CNT_W-1:0] ras_lo_cnt, ras_hi_cnt, cas_lo_cnt;

    // Cycles RAS has been low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || ras_n)     ras_lo_cnt <= '0;
        else if (ras_lo_cnt != '1) ras_lo_cnt <= ras_lo_cnt + 1'b1;
    end

    // Cycles RAS has been high; reset counts as fully precharged.
    always_ff @(posedge clk) begin
        if (!rst_n)              ras_hi_cnt <= '1;
        else if (!ras_n)         ras_hi_cnt <= '0;
        else if (ras_hi_cnt != '1) ras_hi_cnt <= ras_hi_cnt + 1'b1;
    end

    // Cycles CAS has been low.
    always_ff @(posedge clk) begin
        if (!rst_n || cas_n)     cas_lo_cnt <= '0;
        else if (cas_lo_cnt != '1) cas_lo_cnt <= cas_lo_cnt + 1'b1;
    end

    a_r5_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);
    a_r5_rcd: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> (ras_lo_cnt >= CNT_W'(T_RCD)));
    a_r5_cas_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |-> (cas_lo_cnt == CNT_W'(T_CAS)));
    a_r4_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (ras_hi_cnt >= CNT_W'(T_RP)));
    a_r6_we_lead: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && !we_n) |-> !$past(we_n));
    a_r6_write_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && !we_n) |-> dq_oe);
    a_r7_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (we_n && !dq_oe && !cas_n));
    a_r8_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    a_r8_ack_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (cas_n && !ras_n));
endmodule

bind dpc_ctrl dpc_ctrl_chk #(
    .T_RCD (T_RCD),
    .T_CAS (T_CAS),
    .T_RP  (T_RP)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ras_n (dram_ras_n),
    .cas_n (dram_cas_n),
    .we_n  (dram_we_n),
    .oe_n  (dram_oe_n),
    .dq_oe (dram_dq_oe),
    .ack   (host_ack)
);

// File: tb/tb_dpc_ctrl.sv
// Scoreboard bench: a DRAM model stores and returns data from the strobes,
// a driver queues expected results, a monitor compares them on each ack.
module tb_dpc_ctrl;
    localparam int ROW_W = 4, COL_W = 4, DATA_W = 8;
    localparam int T_ASR = 1, T_RCD = 2, T_CAS = 2, T_RP = 2, T_RAS = 3;
    localparam int REF_INTERVAL = 150;
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int AW = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int NR = 1 << ROW_W;
    localparam int NW = 1 << ADDR_W;
    localparam int BURST_GAP = T_ASR + T_RAS + T_RP + 1;

    logic clk = 1'b0, rst_n = 1'b0, ref_burst = 1'b1;
    logic host_req = 1'b0, host_we = 1'b0, host_ack;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [DATA_W-1:0] host_wdata = '0, host_rdata;
    logic [AW-1:0] dram_addr;
    logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [DATA_W-1:0] dram_dq_out, dram_dq_in;

    dpc_ctrl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_ASR(T_ASR), .T_RCD(T_RCD),
        .T_CAS(T_CAS), .T_RP(T_RP), .T_RAS(T_RAS), .REF_INTERVAL(REF_INTERVAL)
    ) dut (
        .clk(clk), .rst_n(rst_n), .ref_burst(ref_burst),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_err = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // DRAM model state
    logic [DATA_W-1:0] mem [NW];
    logic [DATA_W-1:0] shadow [NW];
    logic [ROW_W-1:0] m_row = '0, act_row = '0, last_ref = '0;
    logic [COL_W-1:0] m_col = '0;
    logic prev_ras = 1'b1, prev_cas = 1'b1, saw_cas = 1'b1, saw_wrap = 1'b0;
    int act_cnt = 0, ref_cnt = 0, proto_err = 0, ref_seq_err = 0;
    int fall_time = 0, last_ref_time = 0, last_gap = 0, run = 0, max_run = 0;

    assign dram_dq_in = mem[{m_row, m_col}];

    // Model: latch row/column on strobe falls, store writes, log refreshes.
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_ras = 1'b1;
            prev_cas = 1'b1;
        end else begin
            if (prev_ras && !dram_ras_n) begin
                m_row = dram_addr[ROW_W-1:0];
                saw_cas = 1'b0;
                fall_time = cyc;
            end
            if (prev_cas && !dram_cas_n) begin
                if (dram_ras_n) proto_err++;
                m_col = dram_addr[COL_W-1:0];
                if (!saw_cas) begin
                    act_cnt++;
                    act_row = m_row;
                end
                saw_cas = 1'b1;
                if (!dram_we_n) begin
                    if (!dram_dq_oe) proto_err++;
                    mem[{m_row, m_col}] = dram_dq_out;
                end
            end
            if (!prev_ras && dram_ras_n && !saw_cas) begin
                if (ref_cnt > 0) begin
                    if (m_row != ROW_W'(last_ref + 1'b1)) ref_seq_err++;
                    last_gap = fall_time - last_ref_time;
                    if (last_gap == BURST_GAP) run++;
                    else run = 0;
                    if (run > max_run) max_run = run;
                    if (m_row == '0) saw_wrap = 1'b1;
                end
                last_ref = m_row;
                last_ref_time = fall_time;
                ref_cnt++;
            end
            prev_ras = dram_ras_n;
            prev_cas = dram_cas_n;
        end
    end

    typedef struct {
        logic              is_wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } exp_t;
    exp_t q[$];

    // Driver: queue the expected result, then hold the request until ack.
    task automatic access(input logic we, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] d);
        exp_t e;
        e.is_wr = we;
        e.addr  = a;
        e.data  = we ? d : shadow[a];
        if (we) shadow[a] = d;
        q.push_back(e);
        @(negedge clk);
        host_req = 1'b1;
        host_we = we;
        host_addr = a;
        host_wdata = d;
        do @(negedge clk); while (!host_ack);
        host_req = 1'b0;
    endtask

    // Monitor: one expected item per acknowledge; reads compare data (R7, R8).
    always @(negedge clk) begin
        if (rst_n && host_ack) begin
            if (q.size() == 0) begin
                check(1'b0, "R8", "ack without request", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (!e.is_wr)
                    check(host_rdata == e.data, "R7", "read data", host_rdata, e.data);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R8 watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int a0, r0, t0;
        for (int i = 0; i < NW; i++) begin
            mem[i] = '0;
            shadow[i] = '0;
        end
        repeat (4) @(negedge clk);
        // R1: reset state while held
        check(dram_ras_n && dram_cas_n, "R1", "row/col strobes idle", {dram_ras_n, dram_cas_n}, 3);
        check(dram_we_n && dram_oe_n, "R1", "we/oe idle", {dram_we_n, dram_oe_n}, 3);
        check(!dram_dq_oe && !host_ack, "R1", "no drive, no ack", {dram_dq_oe, host_ack}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dram_ras_n && dram_cas_n && !host_ack, "R1", "first cycle after reset",
              {dram_ras_n, dram_cas_n, host_ack}, 6);

        // R2/R3: write opens row 3, same-row accesses are page hits
        a0 = act_cnt;
        access(1'b1, 8'h31, 8'hA5);
        check(act_cnt - a0 == 1, "R2", "activation on first access", act_cnt - a0, 1);
        check(act_row == 4'h3, "R2", "row on bus at RAS fall", act_row, 3);
        check(m_col == 4'h1, "R2", "column on bus at CAS fall", m_col, 1);
        check(mem[8'h31] == 8'hA5, "R6", "written word stored", mem[8'h31], 8'hA5);
        a0 = act_cnt;
        access(1'b1, 8'h3E, 8'h5C);
        access(1'b0, 8'h31, 8'h00);
        access(1'b0, 8'h3E, 8'h00);
        check(act_cnt == a0, "R3", "hits cause no activation", act_cnt - a0, 0);

        // R4: miss to other rows, then back to row 3
        access(1'b1, 8'h52, 8'h77);
        access(1'b1, 8'h7F, 8'h19);
        a0 = act_cnt;
        access(1'b0, 8'h31, 8'h00);
        check(act_cnt - a0 == 1, "R4", "miss reactivates", act_cnt - a0, 1);
        check(act_row == 4'h3, "R4", "new row after miss", act_row, 3);
        access(1'b0, 8'h52, 8'h00);
        check(act_row == 4'h5, "R4", "row 5 reopened", act_row, 5);

        // R10: distributed refresh spacing with host idle
        ref_burst = 1'b0;
        r0 = ref_cnt;
        t0 = cyc;
        while (ref_cnt < r0 + 3 && cyc - t0 < 5 * REF_INTERVAL) @(negedge clk);
        check(ref_cnt >= r0 + 3, "R10", "refreshes issued", ref_cnt - r0, 3);
        check(last_gap == REF_INTERVAL, "R10", "refresh spacing", last_gap, REF_INTERVAL);

        // R12: refresh closes the open row; next access to it is a miss
        access(1'b0, 8'h3E, 8'h00);
        r0 = ref_cnt;
        t0 = cyc;
        while (ref_cnt == r0 && cyc - t0 < 2 * REF_INTERVAL) @(negedge clk);
        a0 = act_cnt;
        access(1'b0, 8'h31, 8'h00);
        check(act_cnt - a0 == 1, "R12", "access after refresh is a miss", act_cnt - a0, 1);

        // R2/R7: mixed traffic with refresh interleaved
        for (int i = 0; i < 48; i++)
            access((i % 3) != 2, ADDR_W'((i * 37 + 5) % NW), DATA_W'(i * 11 + 3));
        for (int i = 0; i < 48; i++)
            access(1'b0, ADDR_W'((i * 37 + 5) % NW), 8'h00);

        // R11: burst mode refreshes every row back to back
        ref_burst = 1'b1;
        @(negedge clk);
        max_run = 0;
        run = 0;
        t0 = cyc;
        while (max_run < NR - 1 && cyc - t0 < 3 * NR * REF_INTERVAL) @(negedge clk);
        repeat (4 * BURST_GAP) @(negedge clk);
        check(max_run == NR - 1, "R11", "back-to-back refresh run", max_run, NR - 1);

        // R9: refresh row sequence and wrap
        check(ref_seq_err == 0, "R9", "refresh rows consecutive", ref_seq_err, 0);
        check(saw_wrap, "R9", "refresh row wrapped to zero", saw_wrap, 1);
        check(proto_err == 0, "R5", "CAS inside RAS, write data driven", proto_err, 0);
        check(q.size() == 0, "R8", "every request acknowledged", q.size(), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule